// File: doc/BRIEF.md
# Memory-Side Atomic Fetch-and-Add Engine

This engine sits beside the memory controller and completes atomic fetch-and-add operations that travelled all the way to memory because no cache held the line in a writeable state. Each request names a word address, an addend, a tag and the cache that issued it. Requests queue in a small FIFO and are served one at a time, strictly in the order they arrived.

For the request at the head of the queue, the engine first broadcasts an invalidate for the target line to every cache except the requester's. It then waits until each targeted cache has acknowledged. A cache that held modified data returns that data with its acknowledgement, and the engine writes it to memory before doing anything else. Only then does the engine read the word, add the operand, write the sum back and return the value it read. The whole read-modify-write is indivisible: the next queued request is not started until the sum has been written.

Memory is reached through a plain read/write port with a one-cycle read latency. DRAM timing and scheduling are left to the controller behind that port.

Top module: `mc_atomic_add`

## Requirements
- R1: Requests are served and answered strictly in the order in which the FIFO accepted them.
- R2: `req_ready` is low exactly when the FIFO holds DEPTH entries, and a request offered while it is low is not accepted.
- R3: For each request the engine raises `inv_valid` for one cycle, with `inv_addr` equal to the request address and `inv_mask` having bit i set for every cache i except the requesting cache `req_src`.
- R4: No memory read for a request is issued until each cache whose bit is set in `inv_mask` has sent an acknowledgement (`ack_valid[i]`). Acknowledgements from caches outside the mask, or repeated ones, have no effect, including any data they carry.
- R5: An acknowledgement with `ack_dirty[i]` set from a targeted cache causes its data, `ack_data[i*DATA_W +: DATA_W]`, to be written to the request address before the read, so the read returns that data.
- R6: The word at the request address ends up holding the prior value plus the operand, modulo 2^DATA_W. That sum is written in the same cycle as the response.
- R7: `rsp_valid` is a one-cycle pulse carrying `rsp_tag` equal to the request tag and `rsp_data` equal to the word's value before the add (after any writeback).
- R8: At most one request is in flight. A new invalidate is issued only after the previous request's response and sum write.
- R9: While `rst` is held, `req_ready` is 1 and `inv_valid`, `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R10: `mem_rd_en` and `mem_wr_en` are never high in the same cycle, and read data is taken one cycle after `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | FIFO has room |
| req_addr | input | ADDR_W | Target word address |
| req_operand | input | DATA_W | Addend |
| req_tag | input | TAG_W | Request tag, echoed in the response |
| req_src | input | $clog2(NCACHE) | Index of the requesting cache |
| inv_valid | output | 1 | Invalidate broadcast pulse |
| inv_addr | output | ADDR_W | Line being invalidated |
| inv_mask | output | NCACHE | Caches that must acknowledge |
| ack_valid | input | NCACHE | Per-cache acknowledgement |
| ack_dirty | input | NCACHE | Acknowledgement carries modified data |
| ack_data | input | NCACHE*DATA_W | Writeback data, one slice per cache |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | TAG_W | Tag of the completed request |
| rsp_data | output | DATA_W | Value before the add |

## Verification
The assertions assume the following about the environment:
- Memory answers a read exactly one cycle after the strobe.
- Each targeted cache acknowledges an invalidate once, and only after seeing the pulse.
- At most one cache returns modified data for a given line.

The stimulus keeps within these assumptions. Its memory model has a fixed one-cycle latency. Acknowledgements are sent one cache per cycle after the pulse, and at most one targeted cache is marked dirty per request. The only acknowledgement sent outside these rules is a deliberate one from the requesting cache itself, which carries junk data to show that it is ignored.

// File: rtl/mcaa_pkg.sv
package mcaa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MERGE,
    ST_RDWAIT,
    ST_ADD,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/mcaa_fifo.sv
module mcaa_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rptr];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/mcaa_ack_track.sv
module mcaa_ack_track #(
  parameter int NCACHE = 3,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NCACHE-1:0]        start_mask,
  input  logic [NCACHE-1:0]        ack_valid,
  input  logic [NCACHE-1:0]        ack_dirty,
  input  logic [NCACHE*DATA_W-1:0] ack_data,
  output logic                     done,
  output logic                     dirty_now,
  output logic [DATA_W-1:0]        wb_now
);
  logic [NCACHE-1:0] pending, pend_next;
  logic              active, dirty_r;
  logic [DATA_W-1:0] wb_r;

  always_comb begin
    pend_next = pending & ~ack_valid;
    dirty_now = dirty_r;
    wb_now    = wb_r;
    for (int i = 0; i < NCACHE; i++) begin
      if (ack_valid[i] && pending[i] && ack_dirty[i]) begin
        dirty_now = 1'b1;
        wb_now    = ack_data[i*DATA_W +: DATA_W];
      end
    end
    done = active && (pend_next == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= 1'b0;
      dirty_r <= 1'b0;
      wb_r    <= '0;
    end else if (start) begin
      pending <= start_mask;
      active  <= 1'b1;
      dirty_r <= 1'b0;
    end else begin
      pending <= pend_next;
      dirty_r <= dirty_now;
      wb_r    <= wb_now;
      if (done) active <= 1'b0;
    end
  end
endmodule

// File: rtl/mcaa_engine.sv
module mcaa_engine
  import mcaa_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int NCACHE = 3,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              empty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_op,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic [SRC_W-1:0]  head_src,
  output logic              pop,
  output logic [NCACHE-1:0] trk_mask,
  input  logic              trk_done,
  input  logic              trk_dirty,
  input  logic [DATA_W-1:0] trk_wb,
  output logic              inv_valid,
  output logic [NCACHE-1:0] inv_mask,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [NCACHE-1:0] ONE_HOT0 = NCACHE'(1);

  eng_state_t        state;
  logic [DATA_W-1:0] cur_op;
  logic [TAG_W-1:0]  cur_tag;

  assign pop      = (state == ST_IDLE) && !empty;
  assign trk_mask = ~(ONE_HOT0 << head_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      inv_valid <= 1'b0;
      inv_mask  <= '0;
      cur_addr  <= '0;
      cur_op    <= '0;
      cur_tag   <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else begin
      inv_valid <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (pop) begin
          cur_addr  <= head_addr;
          cur_op    <= head_op;
          cur_tag   <= head_tag;
          inv_valid <= 1'b1;
          inv_mask  <= trk_mask;
          state     <= ST_WAIT;
        end
        ST_WAIT: if (trk_done) begin
          if (trk_dirty) begin
            mem_wr_en <= 1'b1;
            mem_wdata <= trk_wb;
            state     <= ST_MERGE;
          end else begin
            mem_rd_en <= 1'b1;
            state     <= ST_RDWAIT;
          end
        end
        ST_MERGE: begin
          mem_rd_en <= 1'b1;
          state     <= ST_RDWAIT;
        end
        ST_RDWAIT: state <= ST_ADD;
        ST_ADD: begin
          mem_wr_en <= 1'b1;
          mem_wdata <= mem_rdata + cur_op;
          rsp_valid <= 1'b1;
          rsp_tag   <= cur_tag;
          rsp_data  <= mem_rdata;
          state     <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mc_atomic_add.sv
module mc_atomic_add #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int NCACHE = 3,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_operand,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [$clog2(NCACHE)-1:0]  req_src,
  output logic                       inv_valid,
  output logic [ADDR_W-1:0]          inv_addr,
  output logic [NCACHE-1:0]          inv_mask,
  input  logic [NCACHE-1:0]          ack_valid,
  input  logic [NCACHE-1:0]          ack_dirty,
  input  logic [NCACHE*DATA_W-1:0]   ack_data,
  output logic                       mem_rd_en,
  output logic                       mem_wr_en,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       rsp_valid,
  output logic [TAG_W-1:0]           rsp_tag,
  output logic [DATA_W-1:0]          rsp_data
);
  localparam int SRC_W = $clog2(NCACHE);
  localparam int ENT_W = SRC_W + TAG_W + DATA_W + ADDR_W;

  logic              full, empty, pop, push;
  logic [ENT_W-1:0]  head;
  logic [NCACHE-1:0] trk_mask;
  logic              trk_done, trk_dirty;
  logic [DATA_W-1:0] trk_wb;
  logic [ADDR_W-1:0] cur_addr;

  assign req_ready = !full;
  assign push      = req_valid && req_ready;
  assign inv_addr  = cur_addr;
  assign mem_addr  = cur_addr;

  mcaa_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push),
    .din({req_src, req_tag, req_operand, req_addr}),
    .pop(pop), .dout(head), .full(full), .empty(empty)
  );

  mcaa_ack_track #(.NCACHE(NCACHE), .DATA_W(DATA_W)) u_track (
    .clk(clk), .rst(rst), .start(pop), .start_mask(trk_mask),
    .ack_valid(ack_valid), .ack_dirty(ack_dirty), .ack_data(ack_data),
    .done(trk_done), .dirty_now(trk_dirty), .wb_now(trk_wb)
  );

  mcaa_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
                .NCACHE(NCACHE), .SRC_W(SRC_W)) u_engine (
    .clk(clk), .rst(rst), .empty(empty),
    .head_addr(head[ADDR_W-1:0]),
    .head_op(head[ADDR_W +: DATA_W]),
    .head_tag(head[ADDR_W+DATA_W +: TAG_W]),
    .head_src(head[ENT_W-1 -: SRC_W]),
    .pop(pop), .trk_mask(trk_mask),
    .trk_done(trk_done), .trk_dirty(trk_dirty), .trk_wb(trk_wb),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .cur_addr(cur_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/mcaa_checker.sv
module mcaa_checker #(
  parameter int NCACHE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              inv_valid,
  input logic [NCACHE-1:0] inv_mask,
  input logic [NCACHE-1:0] ack_valid,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              rsp_valid
);
  logic [NCACHE-1:0] outst;
  logic              busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= '0;
      busy  <= 1'b0;
    end else begin
      outst <= inv_valid ? (inv_mask & ~ack_valid) : (outst & ~ack_valid);
      if (inv_valid)      busy <= 1'b1;
      else if (rsp_valid) busy <= 1'b0;
    end
  end

  // R3
  inv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |=> !inv_valid);

  // R4
  acks_before_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (outst == '0));

  // R8
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !busy);

  // R10
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6
  sum_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> mem_wr_en);
endmodule

bind mc_atomic_add mcaa_checker #(.NCACHE(NCACHE)) u_chk (
  .clk(clk), .rst(rst), .inv_valid(inv_valid), .inv_mask(inv_mask),
  .ack_valid(ack_valid), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .rsp_valid(rsp_valid)
);

// File: tb/mc_atomic_add_test.sv
module mc_atomic_add_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 16, TW = 4, NC = 3, DEP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_operand = '0;
  logic [TW-1:0] req_tag = '0;
  logic [1:0] req_src = '0;
  logic inv_valid;
  logic [AW-1:0] inv_addr;
  logic [NC-1:0] inv_mask;
  logic [NC-1:0] ack_valid = '0, ack_dirty = '0;
  logic [NC*DW-1:0] ack_data = '0;
  logic mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;

  int checks = 0, fails = 0;
  int inv_count = 0, inv_used = 0;
  logic [AW-1:0] last_inv_addr;
  logic [NC-1:0] last_inv_mask;
  logic [DW-1:0] mem_model [16];
  logic [DW-1:0] refm [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_atomic_add #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .NCACHE(NC), .DEPTH(DEP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_operand(req_operand), .req_tag(req_tag), .req_src(req_src),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_mask(inv_mask),
    .ack_valid(ack_valid), .ack_dirty(ack_dirty), .ack_data(ack_data),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 4663 + 17);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem_model[i] <= init_word(i);
      mem_rdata <= '0;
    end else begin
      if (mem_wr_en) mem_model[mem_addr] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem_model[mem_addr];
    end
  end

  // invalidate monitor
  always @(negedge clk) begin
    if (!rst && inv_valid) begin
      inv_count     <= inv_count + 1;
      last_inv_addr <= inv_addr;
      last_inv_mask <= inv_mask;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic push(input logic [TW-1:0] tag, input logic [AW-1:0] addr,
                      input logic [DW-1:0] op, input int src, output bit ok);
    req_valid = 1'b1; req_tag = tag; req_addr = addr; req_operand = op; req_src = 2'(src);
    ok = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic serve(input logic [TW-1:0] tag, input logic [AW-1:0] addr,
                       input logic [DW-1:0] op, input int src, input int dirty_id,
                       input logic [DW-1:0] wbval);
    int n;
    int remaining;
    logic [NC-1:0] msk;
    logic [DW-1:0] old;
    n = 0;
    while (inv_count <= inv_used && n < 80) begin @(negedge clk); n++; end
    chk("R3 invalidate issued", 32'(inv_count > inv_used), 1);
    inv_used++;
    msk = 3'b111 & ~(3'b001 << src);
    chk("R3 inv_addr", 32'(last_inv_addr), 32'(addr));
    chk("R3 inv_mask", 32'(last_inv_mask), 32'(msk));
    old = (dirty_id >= 0) ? wbval : refm[addr];
    // R4: ack from the requester's own cache, dirty with junk, must be ignored
    ack_valid = NC'(1) << src; ack_dirty = NC'(1) << src;
    ack_data = {NC{old ^ 16'h5A5A}};
    @(negedge clk);
    ack_valid = '0; ack_dirty = '0;
    remaining = $countones(msk);
    for (int c = 0; c < NC; c++) begin
      if (msk[c]) begin
        ack_valid = NC'(1) << c;
        ack_dirty = (c == dirty_id) ? (NC'(1) << c) : '0;
        ack_data[c*DW +: DW] = wbval;
        @(negedge clk);
        ack_valid = '0; ack_dirty = '0;
        remaining--;
        if (remaining > 0) begin
          @(negedge clk);
          chk("R4 no read before all acks", 32'(mem_rd_en), 0);
          chk("R4 no response before all acks", 32'(rsp_valid), 0);
        end
      end
    end
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk("R7 rsp_valid", 32'(rsp_valid), 1);
    chk("R1 R7 rsp_tag", 32'(rsp_tag), 32'(tag));
    chk("R5 R7 prior value", 32'(rsp_data), 32'(old));
    @(negedge clk);
    chk("R7 rsp pulse one cycle", 32'(rsp_valid), 0);
    refm[addr] = old + op;
    chk("R6 memory holds sum", 32'(mem_model[addr]), 32'(refm[addr]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int k;
    int nacc;
    logic [TW-1:0] q_tag [8];
    logic [AW-1:0] q_addr [8];
    logic [DW-1:0] q_op [8];
    int q_src [8];
    int q_dirty [8];
    for (int i = 0; i < 16; i++) refm[i] = init_word(i);
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", 32'(req_ready), 1);
    chk("R9 inv idle in reset", 32'(inv_valid), 0);
    chk("R9 rsp idle in reset", 32'(rsp_valid), 0);
    chk("R9 mem idle in reset", 32'({mem_rd_en, mem_wr_en}), 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep: every requester, clean or dirty from each other cache, wrapping sums
    k = 0;
    for (int src = 0; src < NC; src++) begin
      for (int mode = 0; mode < 3; mode++) begin
        int dirty_id;
        logic [AW-1:0] a;
        logic [DW-1:0] op;
        a  = AW'(src * 5 + mode * 3 + 1);
        op = (mode == 2) ? DW'(16'hFFFF - k) : DW'(k * 257 + 3);
        dirty_id = -1;
        if (mode > 0) dirty_id = (src + mode) % NC;
        push(TW'(k), a, op, src, ok);
        chk("R2 accepted when idle", 32'(ok), 1);
        serve(TW'(k), a, op, src, dirty_id, DW'(16'hC000 + k * 11));
        k++;
      end
    end

    // backpressure and ordering: hold acks so the FIFO fills
    nacc = 0;
    for (int j = 0; j < 8; j++) begin
      logic [AW-1:0] a;
      a = (j % 2 == 0) ? AW'(7) : AW'(j);
      push(TW'(8 + j), a, DW'(j * 1000 + 1), j % NC, ok);
      if (!ok) break;
      q_tag[nacc] = TW'(8 + j); q_addr[nacc] = a; q_op[nacc] = DW'(j * 1000 + 1);
      q_src[nacc] = j % NC; q_dirty[nacc] = (j == 3) ? (j + 1) % NC : -1;
      nacc++;
    end
    chk("R2 accepted count at full", 32'(nacc), 32'(DEP + 1));
    chk("R2 ready low when full", 32'(req_ready), 0);
    for (int j = 0; j < nacc; j++)
      serve(q_tag[j], q_addr[j], q_op[j], q_src[j], q_dirty[j], DW'(16'h7777));
    chk("R2 ready back after drain", 32'(req_ready), 1);
    repeat (10) @(negedge clk);
    chk("R2 rejected request not served", 32'(inv_count), 32'(inv_used));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule